// File: doc/BRIEF.md
# Twofish Block Encryption Core

This core encrypts one 128-bit block under a 128-bit key with the Twofish cipher. It is built as a self-contained cipher engine that can be swapped with other engines of the same shape. It has a single-pulse start input, a one-cycle done output, and 128-bit key, plaintext and ciphertext ports. When a start is accepted, the core latches the key and the plaintext. It then expands the key into forty 32-bit subkeys and derives the two S-box key words. After that it applies input whitening, runs sixteen Feistel rounds and applies output whitening.

Two h-function units are shared between the key-expansion phase and the round phase. During key expansion, each cycle yields one subkey pair. During the rounds, each cycle performs one complete round. The ciphertext is held in a register until the next encryption completes.

Top module: `tf_encrypt`

## Requirements
- R1: While reset (active-low `rst_n`) is applied, `done` is low and `ct` is all zeros. This holds even when reset arrives in the middle of an encryption.
- R2: Byte n (n = 0..15) of `key`, `pt` and `ct` sits at bits [127-8n -: 8]. Byte 0 is therefore in bits [127:120]. Each group of four bytes forms one 32-bit word with its first byte as the least significant.
- R3: An all-zero key with an all-zero plaintext yields ciphertext 9F589F5CF6122C32B6BFEC2F2AE8C35A.
- R4: Non-zero keys are expanded correctly. The chained known-answer sequence, in which each key is the ciphertext of two steps earlier and each plaintext is the previous ciphertext, reproduces the published results.
- R5: `start` is accepted only while the core is idle. `key` and `pt` are sampled at that edge, and later changes to them have no effect on the result.
- R6: A `start` pulse while an encryption is in progress, including the cycle in which `done` is high, is ignored. It causes no restart, no change in latency and no further `done`.
- R7: `done` goes high exactly 37 clock edges after the accepting edge. These are 20 key-expansion cycles, one whitening cycle and 16 round cycles. `done` stays high for exactly one cycle.
- R8: `ct` changes only in the cycle in which `done` goes high. It holds its value at all other times, whatever happens on `key`, `pt` and `start`.
- R9: A new `start` issued in the first idle cycle after `done` produces the correct result for its own key and plaintext.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to encrypt; honoured only when idle |
| key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| pt | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| done | output | 1 | One-cycle pulse when `ct` holds a new result |
| ct | output | 128 | Ciphertext block, byte 0 in bits [127:120] |

## Verification
The bench targets four kinds of fault:

- **Byte and word ordering.** It applies the all-zero vector and then the chained known-answer vectors. Reversed byte lanes, swapped q permutations, a wrong field polynomial or reversed S-box key words would each produce a completely different ciphertext.
- **Restart and input sampling.** It changes the key and plaintext in mid-run and pulses `start` twice, once during the rounds and once in the `done` cycle. A design that re-sampled its inputs or restarted would return the wrong block, a longer latency or a second `done`.
- **Back-to-back runs.** The table runs are issued with no gap between them, so leftover subkeys or round state would corrupt the next result.
- **Mid-run reset and output hold.** A reset in mid-run must clear the outputs, and `ct` must hold while the inputs toggle.

// File: rtl/tf_pkg.sv
package tf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_KEY,
        PH_WHITE,
        PH_ROUND,
        PH_DONE
    } phase_t;

    // Nibble tables of the two fixed byte permutations, entry 0 in the top nibble
    localparam logic [63:0] Q0_T0 = 64'h817D6F320B59ECA4;
    localparam logic [63:0] Q0_T1 = 64'hECB81235F4A6709D;
    localparam logic [63:0] Q0_T2 = 64'hBA5E6D90C8F32471;
    localparam logic [63:0] Q0_T3 = 64'hD7F4126E9B3085CA;
    localparam logic [63:0] Q1_T0 = 64'h28BDF76E31940AC5;
    localparam logic [63:0] Q1_T1 = 64'h1E2B4C376DA5F908;
    localparam logic [63:0] Q1_T2 = 64'h4C75169A0ED82B3F;
    localparam logic [63:0] Q1_T3 = 64'hB951C3DE647F208A;

    // Reed-Solomon rows for the S-box key words, coefficient j in byte j from the top
    localparam logic [3:0][63:0] RS_ROWS = {
        64'hA455875A58DB9E03,
        64'h02A1FCC147AE3D19,
        64'hA45682F31EC668E5,
        64'h01A455875A58DB9E
    };

    localparam logic [7:0] MDS_POLY = 8'h69;  // x^8+x^6+x^5+x^3+1
    localparam logic [7:0] RS_POLY  = 8'h4D;  // x^8+x^6+x^3+x^2+1

    function automatic logic [3:0] nib(input logic [63:0] t, input logic [3:0] n);
        logic [63:0] s;
        s = t >> {4'd15 - n, 2'b00};
        return s[3:0];
    endfunction

    function automatic logic [7:0] qperm(input logic sel, input logic [7:0] x);
        logic [3:0] a, b, c, d;
        a = x[7:4];
        b = x[3:0];
        c = a ^ b;
        d = a ^ {b[0], b[3:1]} ^ {a[0], 3'b000};
        a = nib(sel ? Q1_T0 : Q0_T0, c);
        b = nib(sel ? Q1_T1 : Q0_T1, d);
        c = a ^ b;
        d = a ^ {b[0], b[3:1]} ^ {a[0], 3'b000};
        a = nib(sel ? Q1_T2 : Q0_T2, c);
        b = nib(sel ? Q1_T3 : Q0_T3, d);
        return {b, a};
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] poly);
        logic [7:0] acc, sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ({sh[6:0], 1'b0} ^ poly) : {sh[6:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [31:0] mds(input logic [31:0] y);
        logic [7:0] e0, e1, e2, e3, f0, f1, f2, f3;
        e0 = gf_mul(y[7:0],   8'hEF, MDS_POLY);
        e1 = gf_mul(y[15:8],  8'hEF, MDS_POLY);
        e2 = gf_mul(y[23:16], 8'hEF, MDS_POLY);
        e3 = gf_mul(y[31:24], 8'hEF, MDS_POLY);
        f0 = gf_mul(y[7:0],   8'h5B, MDS_POLY);
        f1 = gf_mul(y[15:8],  8'h5B, MDS_POLY);
        f2 = gf_mul(y[23:16], 8'h5B, MDS_POLY);
        f3 = gf_mul(y[31:24], 8'h5B, MDS_POLY);
        return {e0 ^ y[15:8] ^ e2 ^ f3,
                e0 ^ f1 ^ y[23:16] ^ e3,
                f0 ^ e1 ^ e2 ^ y[31:24],
                y[7:0] ^ e1 ^ f2 ^ f3};
    endfunction

    function automatic logic [7:0] rs_dot(input logic [63:0] row, input logic [63:0] m);
        logic [7:0] acc;
        acc = '0;
        for (int j = 0; j < 8; j++)
            acc = acc ^ gf_mul(row[63-8*j -: 8], m[63-8*j -: 8], RS_POLY);
        return acc;
    endfunction

    function automatic logic [31:0] rol32(input logic [31:0] x, input int unsigned n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] bswap32(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

endpackage

// File: rtl/tf_hfunc.sv
module tf_hfunc
    import tf_pkg::*;
(
    input  logic [31:0] x,
    input  logic [31:0] l_out,
    input  logic [31:0] l_in,
    output logic [31:0] z
);
    // Per-byte choice of permutation for the inner, middle and outer stage
    localparam logic [3:0] SEL_INNER = 4'b1010;
    localparam logic [3:0] SEL_MID   = 4'b1100;
    localparam logic [3:0] SEL_OUTER = 4'b0101;

    logic [31:0] y;

    for (genvar b = 0; b < 4; b++) begin : g_byte
        assign y[8*b +: 8] =
            qperm(SEL_OUTER[b],
                  qperm(SEL_MID[b],
                        qperm(SEL_INNER[b], x[8*b +: 8]) ^ l_in[8*b +: 8])
                  ^ l_out[8*b +: 8]);
    end

    assign z = mds(y);
endmodule

// File: rtl/tf_rskey.sv
module tf_rskey
    import tf_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input  logic [KEY_W-1:0]          key_bytes,
    output logic [KEY_W/64-1:0][31:0] sbox_w
);
    localparam int NWORDS = KEY_W / 64;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        logic [63:0] m;
        assign m = key_bytes[KEY_W-1-64*i -: 64];
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign sbox_w[i][8*r +: 8] = rs_dot(RS_ROWS[r], m);
        end
    end
endmodule

// File: rtl/tf_encrypt.sv
module tf_encrypt
    import tf_pkg::*;
#(
    parameter int ROUNDS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [127:0] key,
    input  logic [127:0] pt,
    output logic         done,
    output logic [127:0] ct
);
    localparam int NSUB   = 8 + 2 * ROUNDS;
    localparam int KSTEPS = NSUB / 2;
    localparam int IDX_W  = $clog2(KSTEPS);
    localparam int RIDX_W = $clog2(ROUNDS);
    localparam int SKW    = $clog2(NSUB);

    typedef struct packed {
        phase_t                 phase;
        logic [IDX_W-1:0]       idx;
        logic [127:0]           key;
        logic [3:0][31:0]       r;
        logic [NSUB-1:0][31:0]  sk;
        logic [127:0]           ct;
        logic                   done;
    } st_t;

    st_t st_d, st_q;

    logic [1:0][31:0] sbox_w;
    logic [3:0][31:0] mk;
    logic [1:0][31:0] hx, hl_out, hl_in, hz;
    logic [7:0]       kb_even, kb_odd;
    logic [RIDX_W-1:0] rsel;
    logic [SKW-1:0]   rk0, rk1;
    logic [31:0]      sa, sb, f0, f1;
    logic [3:0][31:0] nr;
    logic             busy;

    tf_rskey #(.KEY_W(128)) u_rskey (
        .key_bytes (st_q.key),
        .sbox_w    (sbox_w)
    );

    for (genvar i = 0; i < 4; i++) begin : g_mkey
        assign mk[i] = bswap32(st_q.key[127-32*i -: 32]);
    end

    assign kb_even = 8'({st_q.idx, 1'b0});
    assign kb_odd  = 8'({st_q.idx, 1'b1});

    // Operand selection for the two shared h units
    always_comb begin
        if (st_q.phase == PH_ROUND) begin
            hx[0]     = st_q.r[0];
            hx[1]     = rol32(st_q.r[1], 8);
            hl_out[0] = sbox_w[1];
            hl_in[0]  = sbox_w[0];
            hl_out[1] = sbox_w[1];
            hl_in[1]  = sbox_w[0];
        end else begin
            hx[0]     = {4{kb_even}};
            hx[1]     = {4{kb_odd}};
            hl_out[0] = mk[0];
            hl_in[0]  = mk[2];
            hl_out[1] = mk[1];
            hl_in[1]  = mk[3];
        end
    end

    for (genvar u = 0; u < 2; u++) begin : g_hunit
        tf_hfunc u_h (
            .x     (hx[u]),
            .l_out (hl_out[u]),
            .l_in  (hl_in[u]),
            .z     (hz[u])
        );
    end

    // Key expansion pair and round function from the shared h outputs
    assign sa   = hz[0];
    assign sb   = rol32(hz[1], 8);
    assign rsel = st_q.idx[RIDX_W-1:0];
    assign rk0  = SKW'(8) + SKW'({rsel, 1'b0});
    assign rk1  = SKW'(9) + SKW'({rsel, 1'b0});
    assign f0   = hz[0] + hz[1] + st_q.sk[rk0];
    assign f1   = hz[0] + {hz[1][30:0], 1'b0} + st_q.sk[rk1];
    assign nr[0] = rol32(st_q.r[2] ^ f0, 31);
    assign nr[1] = rol32(st_q.r[3], 1) ^ f1;
    assign nr[2] = st_q.r[0];
    assign nr[3] = st_q.r[1];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_KEY;
                    st_d.idx   = '0;
                    st_d.key   = key;
                    for (int i = 0; i < 4; i++)
                        st_d.r[i] = bswap32(pt[127-32*i -: 32]);
                end
            end
            PH_KEY: begin
                st_d.sk[{st_q.idx, 1'b0}] = sa + sb;
                st_d.sk[{st_q.idx, 1'b1}] = rol32(sa + {sb[30:0], 1'b0}, 9);
                if (st_q.idx == IDX_W'(KSTEPS - 1)) begin
                    st_d.phase = PH_WHITE;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_WHITE: begin
                for (int i = 0; i < 4; i++)
                    st_d.r[i] = st_q.r[i] ^ st_q.sk[i];
                st_d.phase = PH_ROUND;
            end
            PH_ROUND: begin
                st_d.r = nr;
                if (st_q.idx == IDX_W'(ROUNDS - 1)) begin
                    for (int i = 0; i < 4; i++)
                        st_d.ct[127-32*i -: 32] = bswap32(nr[(i + 2) % 4] ^ st_q.sk[4 + i]);
                    st_d.done  = 1'b1;
                    st_d.phase = PH_DONE;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign done = st_q.done;
    assign ct   = st_q.ct;
endmodule

// File: rtl/tf_encrypt_chk.sv
module tf_encrypt_chk #(
    parameter int ROUNDS = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [127:0] ct
);
    localparam int LAT = (8 + 2 * ROUNDS) / 2 + ROUNDS + 1;

    logic [15:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_q <= '0;
        else if (start && !busy) lat_q <= '0;
        else if (busy)           lat_q <= lat_q + 16'd1;
    end

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Also covers R6: a restart in flight would reset nothing here but shift done
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 16'(LAT)));

    assert_ct_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(ct));
endmodule

bind tf_encrypt tf_encrypt_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ct    (ct)
);

// File: tb/sim_tf_encrypt.sv
module sim_tf_encrypt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] pt = '0;
    logic         done;
    logic [127:0] ct;

    int checks = 0;
    int errors = 0;

    localparam int EXP_LAT = 37;
    localparam int NV = 4;
    // {key, plaintext, ciphertext}; entries 1..3 form the chained sequence
    localparam logic [383:0] VEC [NV] = '{
        {128'h00000000000000000000000000000000,
         128'h00000000000000000000000000000000,
         128'h9F589F5CF6122C32B6BFEC2F2AE8C35A},
        {128'h00000000000000000000000000000000,
         128'h9F589F5CF6122C32B6BFEC2F2AE8C35A,
         128'hD491DB16E7B1C39E86CB086B789F5419},
        {128'h9F589F5CF6122C32B6BFEC2F2AE8C35A,
         128'hD491DB16E7B1C39E86CB086B789F5419,
         128'h019F9809DE1711858FAAC3A3BA20FBC3},
        {128'hD491DB16E7B1C39E86CB086B789F5419,
         128'h019F9809DE1711858FAAC3A3BA20FBC3,
         128'h6363977DE839486297E661C6C9D668EB}
    };

    always #5 clk = ~clk;

    tf_encrypt u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .key   (key),
        .pt    (pt),
        .done  (done),
        .ct    (ct)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] k, input logic [127:0] p, input bit disturb,
                          output logic [127:0] res, output int lat, output bit one_cycle);
        @(negedge clk);
        key = k; pt = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 100) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 5) begin
                key = ~k; pt = ~p; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        res = ct;
        if (disturb) begin
            key = k ^ 128'h5A5A; pt = p ^ 128'hA5A5; start = 1'b1;
        end
        @(negedge clk);
        one_cycle = !done;
        start = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] res, hold;
        int lat;
        bit one, saw_done;

        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", 128'(done), 128'd0);
        chk(ct == '0, "R1 ct in reset", ct, '0);
        rst_n = 1'b1;

        // Table walk, issued back to back (R2, R3, R4, R9, R7)
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][383:256], VEC[v][255:128], 1'b0, res, lat, one);
            chk(res == VEC[v][127:0], v == 0 ? "R3 R2 zero vector" : "R4 R9 chained vector",
                res, VEC[v][127:0]);
            chk(lat == EXP_LAT, "R7 latency", 128'(lat), 128'(EXP_LAT));
            chk(one, "R7 done width", 128'(one), 128'd1);
        end

        // Inputs disturbed and start pulsed mid-run and in the done cycle (R5, R6)
        run_op(VEC[2][383:256], VEC[2][255:128], 1'b1, res, lat, one);
        chk(res == VEC[2][127:0], "R5 sampled inputs", res, VEC[2][127:0]);
        chk(lat == EXP_LAT, "R6 no restart", 128'(lat), 128'(EXP_LAT));
        chk(one, "R7 done width", 128'(one), 128'd1);

        // No run started by the done-cycle start; ct holds while inputs move (R6, R8)
        hold = ct;
        saw_done = 1'b0;
        for (int c = 0; c < 45; c++) begin
            @(negedge clk);
            key = key ^ 128'(c + 1);
            pt = pt + 128'd3;
            if (done) saw_done = 1'b1;
        end
        chk(!saw_done, "R6 ignored start in done cycle", 128'(saw_done), 128'd0);
        chk(ct == hold, "R8 ct held", ct, hold);

        // Reset in mid-run clears the outputs (R1)
        @(negedge clk);
        key = VEC[3][383:256]; pt = VEC[3][255:128]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk(done == 1'b0, "R1 done after mid-run reset", 128'(done), 128'd0);
        chk(ct == '0, "R1 ct after mid-run reset", ct, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Fresh run after reset still gives the right answer (R4)
        run_op(VEC[3][383:256], VEC[3][255:128], 1'b0, res, lat, one);
        chk(res == VEC[3][127:0], "R4 after reset", res, VEC[3][127:0]);
        chk(lat == EXP_LAT, "R7 latency after reset", 128'(lat), 128'(EXP_LAT));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule